// File: doc/BRIEF.md
# Self-Test Request and Completion Register

This block is an 8-bit register shared by two buses. A host configuration bus reads the whole byte and asks for a self-test by writing a 1 into the start bit. It may do so only when the capability flag says a test exists. Once the start bit is set, an interrupt request goes to the local bus. The local side runs its diagnostic, writes a 4-bit result code and clears the start bit. The drop of the start bit marks the result as valid. At that moment the block emits a one-cycle done pulse and a pass/fail verdict.

A boot image can preload the capability flag and the result code. The start bit is never preloaded. A deadline timer watches how long the start bit stays set. If it is still set when the timer expires, the timer raises a sticky timeout flag. The diagnostic itself, the address decoding and the reader for nonvolatile memory lie outside this block.

Byte layout: bit 7 is the capability flag, bit 6 is the start bit, bits 5:4 are always 0 and bits 3:0 are the result code.

Top module: `selftest_ctl_reg`

## Requirements
- R1: After reset the register reads 00h, and `irq_o`, `done_o`, `pass_o` and `timeout_o` are all 0.
- R2: A host write never changes bit 7 or bits 3:0. A host write with bit 6 = 1 sets the start bit only if bit 7 is 1; with bit 7 = 0 the start bit stays 0.
- R3: `irq_o` is 1 exactly while the start bit (bit 6) reads 1.
- R4: Only reset or a local write with bit 6 = 0 clears the start bit. A host write with bit 6 = 0 leaves it set, and a local write with bit 6 = 1 never sets it.
- R5: Bits 5:4 always read 0, whatever is written or boot-loaded.
- R6: A local write loads bit 7 and bits 3:0 from its data byte.
- R7: A boot load copies bit 7 and bits 3:0 from the boot byte and leaves bit 6 unchanged. In the same cycle it takes precedence over a local write for those bits.
- R8: On the clock edge where the start bit goes from 1 to 0, `done_o` pulses high for one cycle. On the same edge, `pass_o` takes the value 1 if the new bits 3:0 are 0 and 0 otherwise, and holds it until the next completion.
- R9: Count the rising edge that sets the start bit as edge 0. If the start bit is still set at rising edge DEADLINE_CYC after it, `timeout_o` becomes 1 and stays 1. A clear that takes effect at an earlier edge prevents the timeout.
- R10: `timeout_o` returns to 0 only on reset or on the edge where the start bit next goes from 0 to 1.
- R11: When a host set and a local clear of the start bit happen in the same cycle, the clear wins and the start bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Host write data |
| loc_wr_i | input | 1 | Local bus write strobe |
| loc_wdata_i | input | 8 | Local bus write data |
| boot_ld_i | input | 1 | Boot-image preload strobe |
| boot_byte_i | input | 8 | Boot-image byte |
| reg_o | output | 8 | Current register byte, seen by both buses |
| irq_o | output | 1 | Interrupt request to the local bus |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Verdict of the last completion |
| timeout_o | output | 1 | Sticky deadline-missed flag |

## Verification
The bench builds the block with DEADLINE_CYC = 16 instead of the 2-second default. With this value both sides of the deadline can be reached in a few dozen cycles: a clear at edge 15 gives no timeout, and a start bit held through edge 16 gives one. The short limit also brings the sticky behaviour and the reset of the flag on a new request within reach of a short run. All other behaviour is independent of the parameter, so the bench covers write gating, boot preload and same-cycle priority directly.

// File: rtl/stcr_pkg.sv
package stcr_pkg;
    // Stored fields of the register; bits 5:4 are not stored.
    typedef struct packed {
        logic       cap;
        logic       start;
        logic [3:0] code;
    } stcr_reg_t;

    localparam int unsigned CAP_BIT   = 7;
    localparam int unsigned START_BIT = 6;

    function automatic logic [7:0] stcr_byte(input stcr_reg_t r);
        return {r.cap, r.start, 2'b00, r.code};
    endfunction
endpackage

// File: rtl/stcr_fields.sv
module stcr_fields
    import stcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_set_i,
    input  logic       loc_wr_i,
    input  logic       loc_cap_i,
    input  logic       loc_start_i,
    input  logic [3:0] loc_code_i,
    input  logic       boot_ld_i,
    input  logic       boot_cap_i,
    input  logic [3:0] boot_code_i,
    output stcr_reg_t  reg_d_o,
    output stcr_reg_t  reg_q_o
);
    stcr_reg_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        // Host may only set the start bit, and only when capable.
        if (host_set_i && reg_q.cap) begin
            reg_d.start = 1'b1;
        end
        if (loc_wr_i) begin
            reg_d.cap  = loc_cap_i;
            reg_d.code = loc_code_i;
            // Local side clears; a local 1 leaves the bit alone. Clear beats host set.
            if (!loc_start_i) begin
                reg_d.start = 1'b0;
            end
        end
        if (boot_ld_i) begin
            reg_d.cap  = boot_cap_i;
            reg_d.code = boot_code_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign reg_d_o = reg_d;
    assign reg_q_o = reg_q;
endmodule

// File: rtl/stcr_deadline.sv
module stcr_deadline #(
    parameter int unsigned DEADLINE_CYC = 200_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_q_i,
    input  logic start_d_i,
    output logic timeout_o
);
    localparam int unsigned CNT_W = $clog2(DEADLINE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEADLINE_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start_d_i && !start_q_i) begin
            tmr_d.cnt  = '0;
            tmr_d.flag = 1'b0;
        end else if (start_q_i && !tmr_q.flag) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.flag = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign timeout_o = tmr_q.flag;
endmodule

// File: rtl/stcr_done.sv
module stcr_done (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_q_i,
    input  logic       start_d_i,
    input  logic [3:0] code_d_i,
    output logic       done_o,
    output logic       pass_o
);
    typedef struct packed {
        logic done;
        logic pass;
    } fin_t;

    fin_t fin_d, fin_q;

    always_comb begin
        fin_d      = fin_q;
        fin_d.done = start_q_i && !start_d_i;
        if (fin_d.done) begin
            fin_d.pass = (code_d_i == 4'h0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_q <= '0;
        end else begin
            fin_q <= fin_d;
        end
    end

    assign done_o = fin_q.done;
    assign pass_o = fin_q.pass;
endmodule

// File: rtl/selftest_ctl_reg.sv
module selftest_ctl_reg
    import stcr_pkg::*;
#(
    parameter int unsigned DEADLINE_CYC = 200_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr_i,
    input  logic [7:0] host_wdata_i,
    input  logic       loc_wr_i,
    input  logic [7:0] loc_wdata_i,
    input  logic       boot_ld_i,
    input  logic [7:0] boot_byte_i,
    output logic [7:0] reg_o,
    output logic       irq_o,
    output logic       done_o,
    output logic       pass_o,
    output logic       timeout_o
);
    stcr_reg_t reg_d, reg_q;
    logic      unused_bits;

    assign unused_bits = ^{host_wdata_i[7], host_wdata_i[5:0],
                           loc_wdata_i[5:4], boot_byte_i[6:4]};

    stcr_fields u_fields (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_set_i  (host_wr_i && host_wdata_i[START_BIT]),
        .loc_wr_i    (loc_wr_i),
        .loc_cap_i   (loc_wdata_i[CAP_BIT]),
        .loc_start_i (loc_wdata_i[START_BIT]),
        .loc_code_i  (loc_wdata_i[3:0]),
        .boot_ld_i   (boot_ld_i),
        .boot_cap_i  (boot_byte_i[CAP_BIT]),
        .boot_code_i (boot_byte_i[3:0]),
        .reg_d_o     (reg_d),
        .reg_q_o     (reg_q)
    );

    stcr_deadline #(.DEADLINE_CYC(DEADLINE_CYC)) u_deadline (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_q_i (reg_q.start),
        .start_d_i (reg_d.start),
        .timeout_o (timeout_o)
    );

    stcr_done u_done (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_q_i (reg_q.start),
        .start_d_i (reg_d.start),
        .code_d_i  (reg_d.code),
        .done_o    (done_o),
        .pass_o    (pass_o)
    );

    assign reg_o = stcr_byte(reg_q);
    assign irq_o = reg_q.start;
endmodule

// File: rtl/stcr_checker.sv
module stcr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr_i,
    input logic [7:0] host_wdata_i,
    input logic       loc_wr_i,
    input logic [7:0] loc_wdata_i,
    input logic [7:0] reg_o,
    input logic       irq_o,
    input logic       done_o,
    input logic       timeout_o
);
    assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_o[5:4] == 2'b00);

    assert_no_set_uncapable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_o[7] && !reg_o[6]) |=> !reg_o[6]);

    assert_hold_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_o[6] && !loc_wr_i) |=> reg_o[6]);

    assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_i && host_wdata_i[6] && loc_wr_i && !loc_wdata_i[6]) |=> !reg_o[6]);

    assert_done_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!reg_o[6] && $past(reg_o[6])));

    assert_irq_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!irq_o && $past(irq_o)));

    assert_timeout_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> $past(reg_o[6]));

    assert_timeout_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timeout_o) |-> (reg_o[6] && !$past(reg_o[6])));
endmodule

bind selftest_ctl_reg stcr_checker u_stcr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_i    (host_wr_i),
    .host_wdata_i (host_wdata_i),
    .loc_wr_i     (loc_wr_i),
    .loc_wdata_i  (loc_wdata_i),
    .reg_o        (reg_o),
    .irq_o        (irq_o),
    .done_o       (done_o),
    .timeout_o    (timeout_o)
);

// File: tb/selftest_ctl_reg_bench.sv
module selftest_ctl_reg_bench;
    localparam int unsigned DL = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr_i = 1'b0;
    logic [7:0] host_wdata_i = '0;
    logic       loc_wr_i = 1'b0;
    logic [7:0] loc_wdata_i = '0;
    logic       boot_ld_i = 1'b0;
    logic [7:0] boot_byte_i = '0;
    logic [7:0] reg_o;
    logic       irq_o, done_o, pass_o, timeout_o;

    int vectors = 0;
    int errors  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    selftest_ctl_reg #(.DEADLINE_CYC(DL)) u_selftest_ctl_reg (
        .clk(clk), .rst_n(rst_n),
        .host_wr_i(host_wr_i), .host_wdata_i(host_wdata_i),
        .loc_wr_i(loc_wr_i), .loc_wdata_i(loc_wdata_i),
        .boot_ld_i(boot_ld_i), .boot_byte_i(boot_byte_i),
        .reg_o(reg_o), .irq_o(irq_o), .done_o(done_o),
        .pass_o(pass_o), .timeout_o(timeout_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at a falling edge, captured at the next rising edge,
    // returns at the following falling edge with outputs settled.
    task automatic cyc(input bit hw, input logic [7:0] hd, input bit lw, input logic [7:0] ld,
                       input bit bl, input logic [7:0] bd);
        @(negedge clk);
        host_wr_i = hw; host_wdata_i = hd;
        loc_wr_i  = lw; loc_wdata_i  = ld;
        boot_ld_i = bl; boot_byte_i  = bd;
        @(negedge clk);
        host_wr_i = 1'b0; loc_wr_i = 1'b0; boot_ld_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reg", reg_o, 8'h00);
        check("R1 outs", {4'h0, irq_o, done_o, pass_o, timeout_o}, 8'h00);
    endtask

    task automatic t_host_gating();
        do_reset();
        cyc(1, 8'hFF, 0, 8'h00, 0, 8'h00);
        check("R2 uncapable host write", reg_o, 8'h00);
        cyc(0, 8'h00, 1, 8'h8A, 0, 8'h00);
        check("R6 local load", reg_o, 8'h8A);
        cyc(1, 8'h7F, 0, 8'h00, 0, 8'h00);
        check("R2 capable set, others kept", reg_o, 8'hCA);
        check("R3 irq high", {7'h0, irq_o}, 8'h01);
        cyc(1, 8'h00, 0, 8'h00, 0, 8'h00);
        check("R4 host zero ignored", reg_o, 8'hCA);
        cyc(0, 8'h00, 1, 8'hF3, 0, 8'h00);
        check("R4 local one keeps start, R5 reserved", reg_o, 8'hC3);
        cyc(0, 8'h00, 1, 8'h83, 0, 8'h00);
        check("R4 local clear", reg_o, 8'h83);
        check("R8 done fail", {6'h0, done_o, pass_o}, 8'h02);
        check("R3 irq low", {7'h0, irq_o}, 8'h00);
        @(negedge clk);
        check("R8 done one cycle", {6'h0, done_o, pass_o}, 8'h00);
        cyc(0, 8'h00, 1, 8'h00, 0, 8'h00);
        check("R8 no done without fall", {7'h0, done_o}, 8'h00);
        cyc(0, 8'h00, 1, 8'h40, 0, 8'h00);
        check("R4 local cannot set", reg_o, 8'h00);
    endtask

    task automatic t_pass();
        do_reset();
        cyc(0, 8'h00, 1, 8'h87, 0, 8'h00);
        cyc(1, 8'h40, 0, 8'h00, 0, 8'h00);
        cyc(0, 8'h00, 1, 8'h80, 0, 8'h00);
        check("R8 done pass", {6'h0, done_o, pass_o}, 8'h03);
        repeat (2) @(negedge clk);
        check("R8 pass held", {6'h0, done_o, pass_o}, 8'h01);
    endtask

    task automatic t_boot();
        do_reset();
        cyc(0, 8'h00, 0, 8'h00, 1, 8'hFF);
        check("R7 boot all ones, R5", reg_o, 8'h8F);
        cyc(1, 8'h40, 0, 8'h00, 0, 8'h00);
        cyc(0, 8'h00, 0, 8'h00, 1, 8'h05);
        check("R7 boot keeps start", reg_o, 8'h45);
        cyc(0, 8'h00, 1, 8'hCF, 1, 8'h82);
        check("R7 boot beats local", reg_o, 8'hC2);
        cyc(0, 8'h00, 0, 8'h00, 1, 8'h30);
        check("R5 boot reserved", reg_o, 8'h40);
    endtask

    task automatic t_priority();
        do_reset();
        cyc(0, 8'h00, 1, 8'h80, 0, 8'h00);
        cyc(1, 8'h40, 1, 8'h81, 0, 8'h00);
        check("R11 clear wins from idle", reg_o, 8'h81);
        cyc(1, 8'h40, 0, 8'h00, 0, 8'h00);
        cyc(1, 8'h40, 1, 8'h84, 0, 8'h00);
        check("R11 clear wins when set", reg_o, 8'h84);
        check("R11 done", {7'h0, done_o}, 8'h01);
    endtask

    task automatic t_deadline();
        do_reset();
        cyc(0, 8'h00, 1, 8'h80, 0, 8'h00);
        cyc(1, 8'h40, 0, 8'h00, 0, 8'h00);   // set edge = edge 0
        repeat (13) @(negedge clk);          // edges 1..13
        cyc(0, 8'h00, 1, 8'h80, 0, 8'h00);   // clear at edge 15
        check("R9 clear before deadline", {7'h0, timeout_o}, 8'h00);
        repeat (20) @(negedge clk);
        check("R9 still no timeout", {7'h0, timeout_o}, 8'h00);
        cyc(1, 8'h40, 0, 8'h00, 0, 8'h00);   // new edge 0
        repeat (DL - 1) @(negedge clk);
        check("R9 not yet at edge 15", {7'h0, timeout_o}, 8'h00);
        @(negedge clk);
        check("R9 timeout at edge 16", {7'h0, timeout_o}, 8'h01);
        cyc(0, 8'h00, 1, 8'h80, 0, 8'h00);
        repeat (3) @(negedge clk);
        check("R10 sticky after clear", {7'h0, timeout_o}, 8'h01);
        cyc(1, 8'h40, 0, 8'h00, 0, 8'h00);
        check("R10 cleared by new set", {7'h0, timeout_o}, 8'h00);
    endtask

    initial begin
        t_reset();
        t_host_gating();
        t_pass();
        t_boot();
        t_priority();
        t_deadline();
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                vectors++;
                $display("FAIL watchdog: actual hung expected finished");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule